// File: doc/BRIEF.md
# Two-Level Address-Space-Tagged Translation Buffer

This block maps 32-bit virtual addresses onto a 29-bit physical space. It has two fully associative levels. A small instruction-side buffer sits in front of a larger unified buffer. Every entry is tagged with an 8-bit address space identifier, and each entry picks its own page size from four choices. The unified level also serves data-side lookups directly, in the same cycle.

When an instruction-side lookup misses the small buffer, hardware searches the unified level and copies the matching entry into the next slot of the small buffer. No software is involved. Software fills the unified level through a single-cycle write port. Each lookup reports a translated address, a miss, or a protection fault. Privileged and user accesses are judged separately by a 2-bit rights code in each entry.

Top module: `xlat_tlb2`

## Requirements
- R1: The page size code is 0 = 1 KB, 1 = 4 KB, 2 = 64 KB and 3 = 1 MB. The physical address takes its bits above the page offset from the entry's frame number, and takes the page offset (bits 9:0, 11:0, 15:0 or 19:0) from the virtual address.
- R2: An entry matches only when its valid bit is set, its address space tag equals `cur_asid`, and its virtual page number equals the lookup's page number above the page offset.
- R3: An instruction lookup that hits the small buffer raises `i_valid` with `i_pa` in the same cycle as `i_req`.
- R4: An instruction lookup that misses the small buffer but hits the unified level is answered on the third clock edge after the request. The sequence is one search cycle, then one fill cycle, then a retry. Afterwards the same page hits with no delay.
- R5: Fills replace the small buffer's 4 slots in round-robin order, starting at slot 0 after reset.
- R6: A lookup that misses both levels raises `i_miss` on the second clock edge. `i_miss` then stays high, with `i_valid` low, for as long as `i_req` is held. It drops in the same cycle that `i_req` falls.
- R7: Rights code bit 1 permits user-mode access and bit 0 permits writes. A user-mode access without bit 1, or a write without bit 0, raises the fault output instead of the valid output. Instruction lookups count as reads.
- R8: A data lookup searches the unified level in the same cycle. It raises exactly one of `d_valid`, `d_fault` or `d_miss`.
- R9: When `wr_en` is high at a clock edge, the fields are stored into the unified slot `wr_idx`. Lookups see the new entry from the next cycle on.
- R10: A unified write invalidates every small-buffer entry that matches the written page number and tag. The next instruction lookup of that page therefore refills and returns the new translation.
- R11: After reset every entry in both levels is invalid, and all outputs are low while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | 8 | Current address space tag |
| user_mode | input | 1 | 1 = user access, 0 = privileged |
| i_req | input | 1 | Instruction lookup request, held until answered |
| i_va | input | 32 | Instruction virtual address |
| i_valid | output | 1 | Instruction translation present |
| i_pa | output | 29 | Instruction physical address |
| i_miss | output | 1 | Miss in both levels |
| i_fault | output | 1 | Instruction protection violation |
| d_req | input | 1 | Data lookup request |
| d_va | input | 32 | Data virtual address |
| d_write | input | 1 | Data access is a write |
| d_valid | output | 1 | Data translation present |
| d_pa | output | 29 | Data physical address |
| d_miss | output | 1 | Data miss in the unified level |
| d_fault | output | 1 | Data protection violation |
| wr_en | input | 1 | Unified entry write strobe |
| wr_idx | input | 6 | Unified slot to write |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_asid | input | 8 | Address space tag of the entry |
| wr_size | input | 2 | Page size code |
| wr_ppn | input | 19 | Frame number (physical bits 28:10) |
| wr_prot | input | 2 | Rights code |

## Verification
The bench probes just past each page boundary for every size. A design that masked the wrong number of bits would translate an address it should reject, or splice the wrong bits into the physical address. It also measures refill and miss latencies edge by edge, and drives five distinct pages through the four-slot buffer. A broken replacement pointer shows up as a hit latency on a page that should have been evicted, or a refill on one that should have stayed. Finally, it rewrites a unified entry whose page is cached in the small buffer. A design without the invalidation would return the stale physical address with no refill delay.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int ASID_W = 8;
    localparam int OFS_W  = 10;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PPN_W  = PA_W - OFS_W;

    typedef enum logic [1:0] {ST_LOOK, ST_SEARCH, ST_FILL, ST_MISS} rf_state_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [1:0]        size;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        prot;
    } tlb_ent_t;

    // Page-number bits that take part in the compare, per size code
    function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        m = '1;
        case (sz)
            2'd0:    m = '1;
            2'd1:    m[1:0] = '0;
            2'd2:    m[5:0] = '0;
            default: m[9:0] = '0;
        endcase
        return m;
    endfunction

    function automatic logic [PA_W-1:0] compose_pa(input tlb_ent_t e, input logic [VA_W-1:0] va);
        logic [VPN_W-1:0] m;
        logic [PPN_W-1:0] keep;
        m    = size_mask(e.size);
        keep = m[PPN_W-1:0];
        return {(e.ppn & keep) | (va[OFS_W +: PPN_W] & ~keep), va[OFS_W-1:0]};
    endfunction

    function automatic logic denied(input logic [1:0] prot, input logic user, input logic wr);
        return (user && !prot[1]) || (wr && !prot[0]);
    endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = 4
) (
    input  tlb_ent_t [N-1:0]       ents,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [ASID_W-1:0]      asid,
    output logic [N-1:0]           hit_vec,
    output logic [$clog2(N)-1:0]   hit_idx
);
    localparam int IW = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].asid == asid)
                         && (((ents[g].vpn ^ vpn) & size_mask(ents[g].size)) == '0);
    end

    // Lowest-numbered hit wins if software left duplicates
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end
endmodule

// File: rtl/xlat_rr.sv
module xlat_rr #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    output logic [$clog2(N)-1:0] ptr
);
    localparam int PW = $clog2(N);
    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) ptr_d = (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    p_rr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr_q == PW'(N - 1)) |=> (ptr_q == '0));
    p_rr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_tlb2.sv
module xlat_tlb2
    import xlat_pkg::*;
#(
    parameter int IT_N = 4,
    parameter int UT_N = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ASID_W-1:0]       cur_asid,
    input  logic                    user_mode,
    input  logic                    i_req,
    input  logic [VA_W-1:0]         i_va,
    output logic                    i_valid,
    output logic [PA_W-1:0]         i_pa,
    output logic                    i_miss,
    output logic                    i_fault,
    input  logic                    d_req,
    input  logic [VA_W-1:0]         d_va,
    input  logic                    d_write,
    output logic                    d_valid,
    output logic [PA_W-1:0]         d_pa,
    output logic                    d_miss,
    output logic                    d_fault,
    input  logic                    wr_en,
    input  logic [$clog2(UT_N)-1:0] wr_idx,
    input  logic                    wr_valid,
    input  logic [VPN_W-1:0]        wr_vpn,
    input  logic [ASID_W-1:0]       wr_asid,
    input  logic [1:0]              wr_size,
    input  logic [PPN_W-1:0]        wr_ppn,
    input  logic [1:0]              wr_prot
);
    localparam int II_W = $clog2(IT_N);
    localparam int UI_W = $clog2(UT_N);

    typedef struct packed {
        rf_state_e              st;
        tlb_ent_t               stage;
        tlb_ent_t [IT_N-1:0]    itlb;
        tlb_ent_t [UT_N-1:0]    utlb;
    } core_t;

    core_t c_d, c_q;

    logic [IT_N-1:0] i_vec, inv_vec;
    logic [II_W-1:0] i_idx, inv_idx, rr_ptr;
    logic [UT_N-1:0] s_vec, d_vec;
    logic [UI_W-1:0] s_idx, d_idx;
    logic            fill;

    xlat_match #(.N(IT_N)) u_imatch (.ents(c_q.itlb), .vpn(i_va[VA_W-1:OFS_W]), .asid(cur_asid),
                                     .hit_vec(i_vec), .hit_idx(i_idx));
    xlat_match #(.N(UT_N)) u_smatch (.ents(c_q.utlb), .vpn(i_va[VA_W-1:OFS_W]), .asid(cur_asid),
                                     .hit_vec(s_vec), .hit_idx(s_idx));
    xlat_match #(.N(UT_N)) u_dmatch (.ents(c_q.utlb), .vpn(d_va[VA_W-1:OFS_W]), .asid(cur_asid),
                                     .hit_vec(d_vec), .hit_idx(d_idx));
    xlat_match #(.N(IT_N)) u_vmatch (.ents(c_q.itlb), .vpn(wr_vpn), .asid(wr_asid),
                                     .hit_vec(inv_vec), .hit_idx(inv_idx));
    xlat_rr    #(.N(IT_N)) u_rr     (.clk(clk), .rst_n(rst_n), .adv(fill), .ptr(rr_ptr));

    assign fill = (c_q.st == ST_FILL);

    tlb_ent_t i_ent, d_ent;
    logic     i_look, i_bad, d_hit, d_bad;

    assign i_ent  = c_q.itlb[i_idx];
    assign d_ent  = c_q.utlb[d_idx];
    assign i_look = (c_q.st == ST_LOOK) && i_req && (|i_vec);
    assign i_bad  = denied(i_ent.prot, user_mode, 1'b0);
    assign d_hit  = |d_vec;
    assign d_bad  = denied(d_ent.prot, user_mode, d_write);

    assign i_valid = i_look && !i_bad;
    assign i_fault = i_look && i_bad;
    assign i_pa    = i_valid ? compose_pa(i_ent, i_va) : '0;
    assign i_miss  = (c_q.st == ST_MISS) && i_req;

    assign d_valid = d_req && d_hit && !d_bad;
    assign d_fault = d_req && d_hit && d_bad;
    assign d_miss  = d_req && !d_hit;
    assign d_pa    = d_valid ? compose_pa(d_ent, d_va) : '0;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_LOOK:   if (i_req && !(|i_vec)) c_d.st = ST_SEARCH;
            ST_SEARCH: begin
                if (!i_req) c_d.st = ST_LOOK;
                else if (|s_vec) begin
                    c_d.stage = c_q.utlb[s_idx];
                    c_d.st    = ST_FILL;
                end else c_d.st = ST_MISS;
            end
            ST_FILL: begin
                c_d.itlb[rr_ptr] = c_q.stage;
                c_d.st           = ST_LOOK;
            end
            ST_MISS:   if (!i_req) c_d.st = ST_LOOK;
            default:   c_d.st = ST_LOOK;
        endcase
        if (wr_en) begin
            c_d.utlb[wr_idx] = '{valid: wr_valid, vpn: wr_vpn, asid: wr_asid,
                                 size: wr_size, ppn: wr_ppn, prot: wr_prot};
            for (int i = 0; i < IT_N; i++) begin
                if (inv_vec[i]) c_d.itlb[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |-> !(i_fault || i_miss));
    p_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        i_miss |=> (i_miss || !i_req));
    p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !wr_en) |=> c_q.itlb[$past(rr_ptr)].valid);
    p_dmiss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_miss) |-> !(d_valid || d_fault));
    p_wr_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid) |=> c_q.utlb[$past(wr_idx)].valid);
    p_inval_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|inv_vec) && !fill) |=> !c_q.itlb[$past(inv_idx)].valid);
endmodule

// File: tb/xlat_tlb2_bench.sv
module xlat_tlb2_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        user_mode = 1'b0;
    logic        i_req = 1'b0;
    logic [31:0] i_va = '0;
    logic        i_valid, i_miss, i_fault;
    logic [28:0] i_pa;
    logic        d_req = 1'b0;
    logic [31:0] d_va = '0;
    logic        d_write = 1'b0;
    logic        d_valid, d_miss, d_fault;
    logic [28:0] d_pa;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [21:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [1:0]  wr_size = '0;
    logic [18:0] wr_ppn = '0;
    logic [1:0]  wr_prot = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xlat_tlb2 u_xlat_tlb2 (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  asid;
        logic        user;
        logic        wr;
        logic        emiss;
        logic        efault;
        logic [28:0] epa;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t DV [NV] = '{
        '{32'h1000_05AB, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 29'h0012_35AB},
        '{32'h1000_05AB, 8'd5, 1'b1, 1'b1, 1'b0, 1'b0, 29'h0012_35AB},
        '{32'h1000_0800, 8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 29'h0},
        '{32'h1000_05AB, 8'd6, 1'b0, 1'b0, 1'b1, 1'b0, 29'h0},
        '{32'h2000_3ABC, 8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 29'h0045_6ABC},
        '{32'h2000_3ABC, 8'd5, 1'b1, 1'b1, 1'b0, 1'b1, 29'h0},
        '{32'h2000_3ABC, 8'd5, 1'b0, 1'b1, 1'b0, 1'b1, 29'h0},
        '{32'h3001_BEEF, 8'd7, 1'b0, 1'b1, 1'b0, 1'b0, 29'h0AB0_BEEF},
        '{32'h3001_BEEF, 8'd7, 1'b1, 1'b0, 1'b0, 1'b1, 29'h0},
        '{32'h3001_BEEF, 8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 29'h0},
        '{32'h401A_BCDE, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 29'h123A_BCDE},
        '{32'h401A_BCDE, 8'd5, 1'b0, 1'b1, 1'b0, 1'b1, 29'h0},
        '{32'h4020_0000, 8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 29'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic load(input logic [5:0] idx, input logic [31:0] va, input logic [7:0] asid,
                        input logic [1:0] sz, input logic [28:0] pa, input logic [1:0] prot);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_valid = 1'b1; wr_vpn = va[31:10];
        wr_asid = asid; wr_size = sz; wr_ppn = pa[28:10]; wr_prot = prot;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drives a held instruction request and counts clock edges until an answer
    task automatic ifetch(input string tag, input logic [31:0] va, input logic [7:0] asid,
                          input logic user, input int exp_lat, input logic [2:0] exp_vfm,
                          input logic [28:0] exp_pa);
        int lat;
        @(negedge clk);
        i_va = va; cur_asid = asid; user_mode = user; i_req = 1'b1; lat = 0;
        #1;
        while (!(i_valid || i_fault || i_miss) && lat < 8) begin
            @(negedge clk);
            lat++;
            #1;
        end
        check({tag, " latency"}, 32'(lat), 32'(exp_lat));
        check({tag, " valid/fault/miss"}, {29'd0, i_valid, i_fault, i_miss}, {29'd0, exp_vfm});
        if (exp_vfm[2]) check({tag, " pa"}, {3'd0, i_pa}, {3'd0, exp_pa});
    endtask

    task automatic idrop;
        @(negedge clk);
        i_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired, run did not complete");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 idle outputs", {28'd0, i_valid, i_miss, d_valid, d_miss}, 32'd0);
        @(negedge clk);
        d_req = 1'b1; d_va = 32'h1000_05AB; cur_asid = 8'd5;
        #1;
        check("R11 empty unified misses", {29'd0, d_valid, d_fault, d_miss}, 32'd1);
        d_req = 1'b0;

        load(6'd0,  32'h1000_0400, 8'd5, 2'd0, 29'h0012_3400, 2'd3);
        load(6'd1,  32'h2000_3000, 8'd5, 2'd1, 29'h0045_6000, 2'd2);
        load(6'd2,  32'h3001_0000, 8'd7, 2'd2, 29'h0AB0_0000, 2'd1);
        load(6'd63, 32'h4010_0000, 8'd5, 2'd3, 29'h1230_0000, 2'd0);
        load(6'd4,  32'h5000_0000, 8'd5, 2'd1, 29'h0050_0000, 2'd3);
        load(6'd5,  32'h6000_0000, 8'd5, 2'd1, 29'h0060_0000, 2'd3);

        // Data-side vectors: sizes R1, matching R2, rights R7, port R8, writes R9
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            d_req = 1'b1; d_va = DV[k].va; cur_asid = DV[k].asid;
            user_mode = DV[k].user; d_write = DV[k].wr;
            #1;
            check($sformatf("R8 R2 R7 vector %0d flags", k), {29'd0, d_valid, d_fault, d_miss},
                  {29'd0, !(DV[k].emiss || DV[k].efault), DV[k].efault, DV[k].emiss});
            if (!(DV[k].emiss || DV[k].efault))
                check($sformatf("R1 R9 vector %0d pa", k), {3'd0, d_pa}, {3'd0, DV[k].epa});
        end
        @(negedge clk);
        d_req = 1'b0; d_write = 1'b0; user_mode = 1'b0;

        ifetch("R4 first refill", 32'h1000_05AB, 8'd5, 1'b0, 3, 3'b100, 29'h0012_35AB);
        idrop();
        ifetch("R3 hit no delay", 32'h1000_0500, 8'd5, 1'b0, 0, 3'b100, 29'h0012_3500);
        idrop();
        ifetch("R6 double miss", 32'h1000_0800, 8'd5, 1'b0, 2, 3'b001, 29'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            check("R6 miss held", {30'd0, i_miss, i_valid}, 32'd2);
        end
        idrop();
        #1;
        check("R6 miss drops with request", {31'd0, i_miss}, 32'd0);

        ifetch("R5 fill slot1", 32'h2000_3010, 8'd5, 1'b1, 3, 3'b100, 29'h0045_6010);
        idrop();
        ifetch("R5 fill slot2", 32'h4010_0020, 8'd5, 1'b0, 3, 3'b100, 29'h1230_0020);
        idrop();
        ifetch("R5 fill slot3", 32'h5000_0004, 8'd5, 1'b0, 3, 3'b100, 29'h0050_0004);
        idrop();
        ifetch("R5 wrap to slot0", 32'h6000_0008, 8'd5, 1'b0, 3, 3'b100, 29'h0060_0008);
        idrop();
        ifetch("R5 slot1 kept", 32'h2000_3010, 8'd5, 1'b1, 0, 3'b100, 29'h0045_6010);
        idrop();
        ifetch("R5 slot0 evicted", 32'h1000_05AB, 8'd5, 1'b0, 3, 3'b100, 29'h0012_35AB);
        idrop();
        ifetch("R2 tag mismatch", 32'h3001_0000, 8'd5, 1'b0, 2, 3'b001, 29'h0);
        idrop();
        ifetch("R7 user fetch fault", 32'h3001_0044, 8'd7, 1'b1, 3, 3'b010, 29'h0);
        idrop();
        ifetch("R7 privileged fetch", 32'h3001_0044, 8'd7, 1'b0, 0, 3'b100, 29'h0AB0_0044);
        idrop();

        load(6'd0, 32'h1000_0400, 8'd5, 2'd0, 29'h0077_7400, 2'd3);
        ifetch("R10 stale copy dropped", 32'h1000_0410, 8'd5, 1'b0, 3, 3'b100, 29'h0077_7410);
        idrop();
        @(negedge clk);
        d_req = 1'b1; d_va = 32'h1000_0410; cur_asid = 8'd5;
        #1;
        check("R9 rewritten entry", {3'd0, d_pa}, {3'd0, 29'h0077_7410});
        d_req = 1'b0;

        report();
        $finish;
    end
endmodule